// File: doc/BRIEF.md
# Resolver Front-End Operating-Mode Controller

This block is the supervisory sequencer of a resolver-interface front end. It holds the surrounding logic in a reset mode while the external reset pin is low or while a supply, clock or thermal condition makes operation unsafe. It releases only after the pin and those conditions have stayed clean for a programmable number of clock cycles, and it then passes through a self-test phase, normal tracking and a latched fault mode. It drives the enables of the exciter boost supply, the exciter amplifier and the digital tracking loop, together with the pull-down of an open-drain fault pin.

Monitored fault flags each come with a mask bit, and the unmasked ones are ORed into one decision. An illegal exciter mode code counts as a fault that cannot be masked. A second group of critical flags is ORed on its own with no mask. It also forces the fault mode, it blocks the fault-clear command, and it is reported on its own output. Host commands arrive as single-cycle strobes, and the current mode comes back as a 2-bit code.

Top module: `rsif_mode_ctrl`

## Requirements
- R1: While the synchronised external reset pin is low, or any of `osc_flt`, `tsd_flt`, `vdd_uv`, `vcc_uv` is high, the mode falls to RESET. The pin takes effect within 4 clocks and the other holds within 2 clocks. In RESET all three enables are 0 and `fault_pull_low` is 1.
- R2: The mode leaves RESET for DIAGNOSTICS only after the hold conditions of R1 have been clear for DEGLITCH_CYC consecutive cycles. A rising pin shows DIAGNOSTICS exactly DEGLITCH_CYC+3 clocks after it rises. Any hold during the count restarts it.
- R3: In DIAGNOSTICS all three enables are 0 and `fault_pull_low` is 1.
- R4: DIAGNOSTICS moves to NORMAL on the next clock when `bist_a_flt`, `bist_l_flt` and `afe_cal_flt` are all 0, or when `cmd_diag_exit` is 1.
- R5: In NORMAL, `boost_en` is 1, `exc_en` follows `cfg_exc_en`, `loop_en` follows `cfg_loop_en`, and `fault_pull_low` is 1.
- R6: In NORMAL with no fault present, `cmd_diag_req` returns the mode to DIAGNOSTICS on the next clock. A fault takes priority over the request.
- R7: Bit i of `mon_msk` suppresses bit i of `mon_flt`. In NORMAL, any unmasked monitor flag moves the mode to FAULT on the next clock, and a masked flag has no effect.
- R8: An `exc_mode` value of 2'b00 or 2'b11 is an unmaskable fault. The values 2'b01 and 2'b10 are legal.
- R9: `crit_any` is the OR of all `crit_flt` bits, `bist_a_flt` and `bist_l_flt`. In NORMAL it moves the mode to FAULT on the next clock.
- R10: In FAULT, `fault_pull_low` is 0, `boost_en` is 1 and `loop_en` is 0. `exc_en` equals `cfg_exc_en` when `cfg_exc_ovr` is 1 and is 0 otherwise.
- R11: FAULT returns to NORMAL only on a `cmd_fault_clr` strobe while no unmasked, illegal-mode or critical fault is present. Otherwise it stays in FAULT.
- R12: `mode_code` reports RESET=0, DIAGNOSTICS=1, NORMAL=2, FAULT=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| osc_flt | input | 1 | Oscillator failure hold |
| tsd_flt | input | 1 | Thermal shutdown hold |
| vdd_uv | input | 1 | Core supply undervoltage hold |
| vcc_uv | input | 1 | Main supply undervoltage hold |
| bist_a_flt | input | 1 | Analog self-test failed |
| bist_l_flt | input | 1 | Logic self-test failed |
| afe_cal_flt | input | 1 | Front-end calibration failed |
| mon_flt | input | 10+2*NCH | Maskable monitor fault flags |
| mon_msk | input | 10+2*NCH | Mask bits, one per monitor flag |
| exc_mode | input | 2 | Exciter mode code |
| crit_flt | input | 10 | Critical fault flags, not maskable |
| cmd_diag_exit | input | 1 | Host strobe: leave diagnostics |
| cmd_diag_req | input | 1 | Host strobe: enter diagnostics |
| cmd_fault_clr | input | 1 | Host strobe: clear fault mode |
| cfg_exc_en | input | 1 | Exciter amplifier enable setting |
| cfg_loop_en | input | 1 | Tracking loop enable setting |
| cfg_exc_ovr | input | 1 | Keep exciter under its setting in FAULT |
| boost_en | output | 1 | Exciter boost supply enable |
| exc_en | output | 1 | Exciter amplifier enable |
| loop_en | output | 1 | Tracking loop enable |
| fault_pull_low | output | 1 | 1 pulls the open-drain fault pin low |
| crit_any | output | 1 | Critical fault aggregate |
| mode_code | output | 2 | Current mode code |

## Verification
The assertions take the hold flags, fault flags and settings to be synchronous to `clk`. Only the external reset pin passes through the synchroniser. The host commands are taken to be single-cycle strobes, so a held strobe would be seen again on every clock. The stimulus changes every input shortly after a rising edge and raises each command for exactly one cycle. It holds the calibration flag high whenever the test needs the mode to stay in DIAGNOSTICS, so that self-test exit does not race the command under test.

// File: rtl/rsif_mode_pkg.sv
// Shared types and constants for the resolver front-end mode controller.
// Assumes a 2-bit mode code that software decodes, so the encoding is fixed.
package rsif_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'd0,
        MODE_DIAG   = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_FAULT  = 2'd3
    } rsif_mode_e;

    // Number of fixed maskable monitor flags ahead of the per-channel ones.
    localparam int FIXED_MON = 10;
    // Number of critical, unmaskable flags.
    localparam int NCRIT     = 10;

    // Legal exciter mode codes are 01 and 10.
    function automatic logic exc_mode_bad(input logic [1:0] code);
        return (code == 2'b00) || (code == 2'b11);
    endfunction

endpackage

// File: rtl/rsif_rst_gate.sv
// Reset gate: synchronises the external reset pin and ORs it with the
// supply, clock and thermal holds. It then requires DEGLITCH_CYC
// consecutive clean cycles before it raises run_o.
// Assumes the hold flags are already synchronous to clk.
module rsif_rst_gate #(
    parameter int DEGLITCH_CYC = 7000,
    localparam int CW = $clog2(DEGLITCH_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst_n,
    input  logic osc_flt,
    input  logic tsd_flt,
    input  logic vdd_uv,
    input  logic vcc_uv,
    output logic run_o
);

    logic          pin_s1, pin_s2;
    logic          hold;
    logic [CW-1:0] clean_cnt;

    // Two-flop synchroniser for the asynchronous reset pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= 1'b0;
            pin_s2 <= 1'b0;
        end else begin
            pin_s1 <= ext_rst_n;
            pin_s2 <= pin_s1;
        end
    end

    // Any hold source keeps the logic frozen.
    always_comb hold = !pin_s2 || osc_flt || tsd_flt || vdd_uv || vcc_uv;

    // Deglitch counter: counts clean cycles and releases at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            clean_cnt <= '0;
            run_o     <= 1'b0;
        end else if (!run_o) begin
            if (clean_cnt == CW'(DEGLITCH_CYC - 1)) begin
                run_o <= 1'b1;
            end else begin
                clean_cnt <= clean_cnt + 1'b1;
            end
        end
    end

    // A hold seen at an edge always drops run on that edge.
    assert_hold_blocks_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !run_o);

    // Release only ever follows a clean cycle.
    assert_release_after_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(!hold));

endmodule

// File: rtl/rsif_fault_agg.sv
// Fault aggregator: gates each monitor flag with its mask bit and adds the
// illegal exciter mode code to form the maskable-path fault. It ORs the
// critical flags and both self-test failures into a separate aggregate.
// Purely combinational.
module rsif_fault_agg
    import rsif_mode_pkg::*;
#(
    parameter int NMON = 16
) (
    input  logic [NMON-1:0]  mon_flt,
    input  logic [NMON-1:0]  mon_msk,
    input  logic [1:0]       exc_mode,
    input  logic [NCRIT-1:0] crit_flt,
    input  logic             bist_a_flt,
    input  logic             bist_l_flt,
    output logic             mon_any_o,
    output logic             crit_any_o
);

    logic [NMON-1:0] gated;

    // One mask gate per monitor flag.
    for (genvar gi = 0; gi < NMON; gi++) begin : g_gate
        always_comb gated[gi] = mon_flt[gi] & ~mon_msk[gi];
    end

    // Maskable-path decision, including the illegal mode code.
    always_comb mon_any_o = (|gated) || exc_mode_bad(exc_mode);

    // Critical aggregate, which has no mask.
    always_comb crit_any_o = (|crit_flt) || bist_a_flt || bist_l_flt;

endmodule

// File: rtl/rsif_mode_fsm.sv
// Mode state machine and enable decode. Assumes all commands are
// single-cycle strobes and the fault aggregates are synchronous to clk.
// Falls to RESET whenever run_i is low.
module rsif_mode_fsm
    import rsif_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       bist_ok_i,
    input  logic       mon_any_i,
    input  logic       crit_any_i,
    input  logic       cmd_diag_exit,
    input  logic       cmd_diag_req,
    input  logic       cmd_fault_clr,
    input  logic       cfg_exc_en,
    input  logic       cfg_loop_en,
    input  logic       cfg_exc_ovr,
    output logic       boost_en,
    output logic       exc_en,
    output logic       loop_en,
    output logic       fault_pull_low,
    output logic [1:0] mode_code
);

    rsif_mode_e state, state_nx;
    logic       any_flt;

    // Combined fault condition from both aggregates.
    always_comb any_flt = mon_any_i || crit_any_i;

    // Next-mode selection; a fault outranks a diagnostics request.
    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_RESET:  state_nx = MODE_DIAG;
            MODE_DIAG:   if (bist_ok_i || cmd_diag_exit) state_nx = MODE_NORMAL;
            MODE_NORMAL: if (any_flt) state_nx = MODE_FAULT;
                         else if (cmd_diag_req) state_nx = MODE_DIAG;
            MODE_FAULT:  if (cmd_fault_clr && !any_flt) state_nx = MODE_NORMAL;
            default:     state_nx = MODE_RESET;
        endcase
    end

    // Mode register, frozen in RESET while run is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) state <= MODE_RESET;
        else                  state <= state_nx;
    end

    // Per-mode enable and fault-pin decode.
    always_comb begin
        boost_en       = 1'b0;
        exc_en         = 1'b0;
        loop_en        = 1'b0;
        fault_pull_low = 1'b1;
        case (state)
            MODE_NORMAL: begin
                boost_en = 1'b1;
                exc_en   = cfg_exc_en;
                loop_en  = cfg_loop_en;
            end
            MODE_FAULT: begin
                boost_en       = 1'b1;
                exc_en         = cfg_exc_ovr & cfg_exc_en;
                fault_pull_low = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb mode_code = state;

    // An active fault in NORMAL leads to FAULT on the next clock.
    assert_normal_to_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_NORMAL && run_i && any_flt) |=> state == MODE_FAULT);

    // FAULT is held unless a clean clear strobe arrives.
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_FAULT && run_i && (!cmd_fault_clr || any_flt)) |=> state == MODE_FAULT);

    // Without run the mode is RESET on the next clock.
    assert_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> state == MODE_RESET);

endmodule

// File: rtl/rsif_mode_ctrl.sv
// Top of the resolver front-end mode controller. It connects the reset
// gate, the fault aggregator and the mode state machine. NCH sets the
// number of input channels with over- and undervoltage monitors.
// DEGLITCH_CYC is the release delay in clocks (7000 gives 70 us at 100 MHz).
module rsif_mode_ctrl
    import rsif_mode_pkg::*;
#(
    parameter int NCH          = 3,
    parameter int DEGLITCH_CYC = 7000,
    localparam int NMON        = FIXED_MON + 2 * NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_n,
    input  logic             osc_flt,
    input  logic             tsd_flt,
    input  logic             vdd_uv,
    input  logic             vcc_uv,
    input  logic             bist_a_flt,
    input  logic             bist_l_flt,
    input  logic             afe_cal_flt,
    input  logic [NMON-1:0]  mon_flt,
    input  logic [NMON-1:0]  mon_msk,
    input  logic [1:0]       exc_mode,
    input  logic [NCRIT-1:0] crit_flt,
    input  logic             cmd_diag_exit,
    input  logic             cmd_diag_req,
    input  logic             cmd_fault_clr,
    input  logic             cfg_exc_en,
    input  logic             cfg_loop_en,
    input  logic             cfg_exc_ovr,
    output logic             boost_en,
    output logic             exc_en,
    output logic             loop_en,
    output logic             fault_pull_low,
    output logic             crit_any,
    output logic [1:0]       mode_code
);

    logic run;
    logic mon_any;
    logic bist_ok;

    // Self-test pass needs both self-tests and calibration clean.
    always_comb bist_ok = !bist_a_flt && !bist_l_flt && !afe_cal_flt;

    rsif_rst_gate #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_rst_n (ext_rst_n),
        .osc_flt   (osc_flt),
        .tsd_flt   (tsd_flt),
        .vdd_uv    (vdd_uv),
        .vcc_uv    (vcc_uv),
        .run_o     (run)
    );

    rsif_fault_agg #(.NMON(NMON)) u_agg (
        .mon_flt    (mon_flt),
        .mon_msk    (mon_msk),
        .exc_mode   (exc_mode),
        .crit_flt   (crit_flt),
        .bist_a_flt (bist_a_flt),
        .bist_l_flt (bist_l_flt),
        .mon_any_o  (mon_any),
        .crit_any_o (crit_any)
    );

    rsif_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run),
        .bist_ok_i      (bist_ok),
        .mon_any_i      (mon_any),
        .crit_any_i     (crit_any),
        .cmd_diag_exit  (cmd_diag_exit),
        .cmd_diag_req   (cmd_diag_req),
        .cmd_fault_clr  (cmd_fault_clr),
        .cfg_exc_en     (cfg_exc_en),
        .cfg_loop_en    (cfg_loop_en),
        .cfg_exc_ovr    (cfg_exc_ovr),
        .boost_en       (boost_en),
        .exc_en         (exc_en),
        .loop_en        (loop_en),
        .fault_pull_low (fault_pull_low),
        .mode_code      (mode_code)
    );

    // An illegal exciter code in a running NORMAL mode forces FAULT.
    assert_bad_code_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'd2 && run && exc_mode_bad(exc_mode)) |=> mode_code == 2'd3);

    // The fault mode releases the pin and stops the loop but keeps the boost on.
    assert_fault_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code == 2'd3 |-> (!fault_pull_low && boost_en && !loop_en));

    // A self-test pass in a running DIAGNOSTICS mode leads to NORMAL.
    assert_diag_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'd1 && run && bist_ok) |=> mode_code == 2'd2);

    // Whenever the block is out of NORMAL and FAULT, all enables are off.
    assert_quiet_modes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code < 2'd2) |-> (!boost_en && !exc_en && !loop_en && fault_pull_low));

endmodule

// File: tb/rsif_mode_ctrl_tb.sv
// Bench for rsif_mode_ctrl: a behavioural reference model compared on every
// clock, plus directed checks of each requirement.
module rsif_mode_ctrl_tb;

    localparam int NCH  = 3;
    localparam int DEG  = 40;
    localparam int NMON = 10 + 2 * NCH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst_n = 1'b0;
    logic osc_flt = 0, tsd_flt = 0, vdd_uv = 0, vcc_uv = 0;
    logic bist_a_flt = 0, bist_l_flt = 0, afe_cal_flt = 1;
    logic [NMON-1:0] mon_flt = '0, mon_msk = '0;
    logic [1:0] exc_mode = 2'b01;
    logic [9:0] crit_flt = '0;
    logic cmd_diag_exit = 0, cmd_diag_req = 0, cmd_fault_clr = 0;
    logic cfg_exc_en = 1, cfg_loop_en = 1, cfg_exc_ovr = 0;
    logic boost_en, exc_en, loop_en, fault_pull_low, crit_any;
    logic [1:0] mode_code;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rsif_mode_ctrl #(.NCH(NCH), .DEGLITCH_CYC(DEG)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .osc_flt(osc_flt), .tsd_flt(tsd_flt), .vdd_uv(vdd_uv), .vcc_uv(vcc_uv),
        .bist_a_flt(bist_a_flt), .bist_l_flt(bist_l_flt), .afe_cal_flt(afe_cal_flt),
        .mon_flt(mon_flt), .mon_msk(mon_msk), .exc_mode(exc_mode), .crit_flt(crit_flt),
        .cmd_diag_exit(cmd_diag_exit), .cmd_diag_req(cmd_diag_req),
        .cmd_fault_clr(cmd_fault_clr), .cfg_exc_en(cfg_exc_en),
        .cfg_loop_en(cfg_loop_en), .cfg_exc_ovr(cfg_exc_ovr),
        .boost_en(boost_en), .exc_en(exc_en), .loop_en(loop_en),
        .fault_pull_low(fault_pull_low), .crit_any(crit_any), .mode_code(mode_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model state: a pin delay line, a clean-cycle count, a run flag and a mode.
    int m_p1, m_p2, m_cnt, m_run, m_st, m_nst;
    bit m_flt, m_crit, m_hold;

    function automatic bit ref_mon_fault();
        bit f = (exc_mode == 2'b00) || (exc_mode == 2'b11);
        for (int i = 0; i < NMON; i++) if (mon_flt[i] && !mon_msk[i]) f = 1;
        return f;
    endfunction

    always @(posedge clk) begin
        cyc++;
        m_flt  = ref_mon_fault();
        m_crit = (crit_flt != 0) || bist_a_flt || bist_l_flt;
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_cnt = 0; m_run = 0; m_st = 0;
        end else begin
            m_nst = m_st;
            if (m_run == 0) m_nst = 0;
            else if (m_st == 0) m_nst = 1;
            else if (m_st == 1) begin
                if (cmd_diag_exit || (!bist_a_flt && !bist_l_flt && !afe_cal_flt)) m_nst = 2;
            end else if (m_st == 2) begin
                if (m_flt || m_crit) m_nst = 3;
                else if (cmd_diag_req) m_nst = 1;
            end else begin
                if (cmd_fault_clr && !m_flt && !m_crit) m_nst = 2;
            end
            m_hold = (m_p2 == 0) || osc_flt || tsd_flt || vdd_uv || vcc_uv;
            if (m_hold) begin
                m_cnt = 0; m_run = 0;
            end else if (m_run == 0) begin
                if (m_cnt == DEG - 1) m_run = 1;
                else m_cnt++;
            end
            m_p2 = m_p1;
            m_p1 = int'(ext_rst_n);
            m_st = m_nst;
        end
    end

    // Per-clock comparison of every output against the model, on the falling edge.
    always @(negedge clk) begin
        int eb, ee, el, ep, ec, act, exp;
        string tag;
        if (!done) begin
            eb = (m_st >= 2) ? 1 : 0;
            ee = (m_st == 2) ? int'(cfg_exc_en) : (m_st == 3) ? int'(cfg_exc_en && cfg_exc_ovr) : 0;
            el = (m_st == 2) ? int'(cfg_loop_en) : 0;
            ep = (m_st == 3) ? 0 : 1;
            ec = ((crit_flt != 0) || bist_a_flt || bist_l_flt) ? 1 : 0;
            exp = (m_st << 5) | (eb << 4) | (ee << 3) | (el << 2) | (ep << 1) | ec;
            act = (int'(mode_code) << 5) | (int'(boost_en) << 4) | (int'(exc_en) << 3) |
                  (int'(loop_en) << 2) | (int'(fault_pull_low) << 1) | int'(crit_any);
            case (m_st)
                0: tag = "R1 model RESET R12";
                1: tag = "R3 model DIAG R12";
                2: tag = "R5 model NORMAL R12";
                default: tag = "R10 model FAULT R9 R12";
            endcase
            chk(act == exp, tag, act, exp);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_mode(input int m, input string tag);
        #2;
        chk(int'(mode_code) == m, tag, int'(mode_code), m);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        step(3);
        expect_mode(0, "R12 reset value");
        rst_n = 1'b1;
        step(5);
        expect_mode(0, "R1 pin low holds RESET");
        chk(fault_pull_low && !boost_en, "R1 reset outputs", int'(fault_pull_low), 1);

        // R2: release timing from the pin rising.
        ext_rst_n = 1'b1;
        step(DEG + 2);
        expect_mode(0, "R2 still RESET before deglitch end");
        step(1);
        expect_mode(1, "R2 DIAGNOSTICS after deglitch");
        step(3);
        expect_mode(1, "R3 held in DIAGNOSTICS by calibration flag");
        chk(!boost_en && !exc_en && !loop_en && fault_pull_low, "R3 diag outputs", int'(boost_en), 0);

        // R4: host exit strobe.
        cmd_diag_exit = 1; step(1); cmd_diag_exit = 0;
        expect_mode(2, "R4 exit by command");

        // R5: enables under several settings.
        cfg_exc_en = 0; cfg_loop_en = 1; step(1);
        chk(!exc_en && loop_en && boost_en, "R5 exc off loop on", int'(exc_en), 0);
        cfg_exc_en = 1; cfg_loop_en = 0; step(1);
        chk(exc_en && !loop_en && boost_en, "R5 exc on loop off", int'(loop_en), 0);
        cfg_loop_en = 1;

        // R6: request diagnostics, then R4 exit on self-test pass.
        cmd_diag_req = 1; step(1); cmd_diag_req = 0;
        expect_mode(1, "R6 diag request");
        afe_cal_flt = 0; step(1);
        expect_mode(2, "R4 exit on self-test pass");

        // R7: masked flag ignored, unmasked flag faults.
        mon_msk[12] = 1; mon_flt[12] = 1; step(3);
        expect_mode(2, "R7 masked flag ignored");
        mon_msk[12] = 0; step(1);
        expect_mode(3, "R7 unmasked flag faults");
        cfg_exc_ovr = 0; step(1);
        chk(!exc_en && boost_en && !loop_en && !fault_pull_low, "R10 fault, override off", int'(exc_en), 0);
        cfg_exc_ovr = 1; step(1);
        chk(exc_en, "R10 fault, override on", int'(exc_en), 1);

        // R11: clear refused while the fault is active, accepted once it is gone.
        cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;
        expect_mode(3, "R11 clear with fault active");
        mon_flt[12] = 0; step(2);
        expect_mode(3, "R11 no clear strobe stays");
        cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;
        expect_mode(2, "R11 clear accepted");

        // R8: illegal exciter codes.
        exc_mode = 2'b10; step(2);
        expect_mode(2, "R8 code 10 legal");
        exc_mode = 2'b00; step(1);
        expect_mode(3, "R8 code 00 faults");
        exc_mode = 2'b01; cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;
        expect_mode(2, "R8 recovered");
        exc_mode = 2'b11; step(1);
        expect_mode(3, "R8 code 11 faults");
        exc_mode = 2'b01; cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;

        // R9: critical aggregate forces and holds FAULT.
        crit_flt[4] = 1; #2;
        chk(crit_any, "R9 crit_any follows flag", int'(crit_any), 1);
        step(1);
        expect_mode(3, "R9 critical flag faults");
        cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;
        expect_mode(3, "R11 clear blocked by critical");
        crit_flt[4] = 0; cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;
        expect_mode(2, "R9 recovered");
        bist_l_flt = 1; step(1);
        expect_mode(3, "R9 logic self-test fault");
        bist_l_flt = 0; cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;

        // R6 priority: a fault outranks the request.
        mon_flt[0] = 1; cmd_diag_req = 1; step(1); cmd_diag_req = 0;
        expect_mode(3, "R6 fault outranks request");
        mon_flt[0] = 0; cmd_fault_clr = 1; step(1); cmd_fault_clr = 0;
        expect_mode(2, "R11 back to NORMAL");

        // R1/R2: an oscillator pulse freezes and restarts the deglitch.
        osc_flt = 1; step(1); osc_flt = 0; step(1);
        expect_mode(0, "R1 oscillator hold");
        step(DEG - 1);
        expect_mode(0, "R2 count restarted");
        step(1);
        expect_mode(1, "R2 release after restart");
        step(2);

        // R1: the pin going low forces RESET within 4 clocks.
        ext_rst_n = 0; step(4);
        expect_mode(0, "R1 pin low");
        step(5);
        finish_run();
    end

endmodule